// File: doc/BRIEF.md
# Dynamic Bus Sizing Splitter

This block sits between an internal master that issues 32-bit-bus requests and an external port. The port may be 8, 16 or 32 bits wide. For each request it takes the port width of the selected bank as an input. It then turns the access into one or more external beats of the port's natural width, issued in ascending address order. Lanes are big-endian: lane 0 is the most significant byte, `bt_wdata[31:24]`. Narrow ports use only the top one or two lanes.

On the master side, a request is taken when `req_valid` and `req_ready` are both high. On the external side, each beat completes when `bt_valid` and `bt_ready` are both high, and any read data is captured on that beat. After the last beat the block raises a one-cycle `rsp_valid`. For a read, the response carries the bytes put back into their natural 32-bit positions. Requests from external masters skip the splitting and go out as one full-width beat. Misaligned or malformed requests get an error response without touching the bus.

Top module: `dyn_bus_sizer`

## Requirements
- R1: `req_ready` is high only when no request is in progress. A request is taken when `req_valid` and `req_ready` are both high at a rising edge. Each taken request produces exactly one `rsp_valid` pulse, lasting one cycle. The pulse comes in the cycle after the final beat handshake, or in the cycle after acceptance for an error.
- R2: Port code 0 is an 8-bit port. Sizes are coded 0 byte, 1 half-word, 2 word. On this port a byte takes 1 beat, a half-word 2 beats and a word 4 beats. The beat addresses are addr, addr+1, and so on upward. Every beat has `bt_be` = 4'b1000 and carries its byte on `bt_wdata[31:24]`.
- R3: Port code 1 is a 16-bit port. A byte takes one beat: at an even address it uses lane 0 (`bt_be` 4'b1000, bits 31:24), and at an odd address lane 1 (4'b0100, bits 23:16). A half-word is one beat with `bt_be` 4'b1100. A word is two beats, at addr and addr+2.
- R4: Port code 2 is a 32-bit port. Every request is a single beat at the request address. The enabled lanes are the bytes' natural positions: byte offset k maps to `bt_be[3-k]` and bits 31-8k down to 24-8k. Data is unchanged in those lanes.
- R5: On a read response, `rsp_rdata` holds each requested byte at its natural position. The byte comes from the lane it was returned on. All other bytes are zero. A write response has `rsp_rdata` zero.
- R6: With `req_ext` high, the request is issued as one beat exactly as R4, whatever `req_port` says.
- R7: An error response has `rsp_err` high and no beat is issued. The causes are: a half-word at an odd address, a word not on a 4-byte boundary, size code 3, or port code 3 on an internal request.
- R8: While `bt_valid` is high and `bt_ready` low, `bt_addr`, `bt_be`, `bt_wdata` and `bt_write` hold their values into the next cycle.
- R9: Lanes whose `bt_be` bit is low carry zero on `bt_wdata`, and all of `bt_wdata` is zero on read beats. `bt_write` follows `req_write`.
- R10: During and just after reset, `req_ready` is high and both `bt_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_write | input | 1 | 1 for write |
| req_wdata | input | 32 | Write data in natural lanes |
| req_port | input | 2 | Bank port width: 0 8-bit, 1 16-bit, 2 32-bit |
| req_ext | input | 1 | Request from an external master (single beat) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is an error |
| rsp_rdata | output | 32 | Reassembled read data |
| bt_valid | output | 1 | External beat valid |
| bt_ready | input | 1 | External beat accepted |
| bt_addr | output | ADDR_W | Beat byte address |
| bt_write | output | 1 | Beat direction |
| bt_be | output | 4 | Lane enables, bit 3 is lane 0 |
| bt_wdata | output | 32 | Beat write data, lane 0 at bits 31:24 |
| bt_rdata | input | 32 | Beat read data, taken at handshake |

## Verification
A wrong beat count shows up within one beat handshake. Either `rsp_valid` arrives while more beats were expected, or `bt_valid` is still high where the response was due. A bad beat index or width code shows up on the next beat as a wrong `bt_addr` or misplaced `bt_be` lanes. A wrong merge into the read accumulator is hidden until the response, where the affected byte of `rsp_rdata` differs. Stalls are held for random lengths, so a beat that drifts while waiting shows up on the very next sampled cycle.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      PW_8    = 2'd0,
      PW_16   = 2'd1,
      PW_32   = 2'd2,
      PW_RSVD = 2'd3
   } port_w_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BEAT = 2'd1,
      ST_RESP = 2'd2
   } seq_state_e;

   // Outcome of decoding one request: error flag, log2 of the beat
   // width in bytes, and index of the final beat.
   typedef struct packed {
      logic       err;
      logic [1:0] wlog;
      logic [1:0] last_idx;
   } plan_t;

endpackage

// File: rtl/dbs_plan.sv
module dbs_plan
   import dbs_pkg::*;
#(
   parameter bit EXT_BYPASS = 1'b1
) (
   input  logic [1:0] addr_lo,
   input  xfer_size_e size,
   input  port_w_e    port,
   input  logic       ext,
   output plan_t      plan
);

   logic       full_width;
   logic [1:0] sz;
   logic [1:0] wl;
   logic [1:0] span;
   logic       misal;
   logic       bad_cfg;

   generate
      if (EXT_BYPASS) begin : g_bypass
         assign full_width = ext;
      end else begin : g_nobypass
         assign full_width = 1'b0;
      end
   endgenerate

   assign sz = size;

   always_comb begin
      wl      = full_width ? 2'd2 : port;
      bad_cfg = (size == SZ_RSVD) || (!full_width && (port == PW_RSVD));
      misal   = ((size == SZ_HALF) && addr_lo[0]) ||
                ((size == SZ_WORD) && (addr_lo != 2'd0));
      span    = sz - wl;
      plan.err      = bad_cfg || misal;
      plan.wlog     = wl;
      plan.last_idx = 2'd0;
      if (!plan.err && (sz > wl)) begin
         plan.last_idx = (span == 2'd1) ? 2'd1 : 2'd3;
      end
   end

endmodule

// File: rtl/dbs_lane.sv
module dbs_lane
   import dbs_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [$clog2(LANES)-1:0] beat_off,
   input  logic [$clog2(LANES)-1:0] req_off,
   input  xfer_size_e               size,
   input  logic [1:0]               wlog,
   input  logic                     write,
   input  logic [8*LANES-1:0]       wdata_nat,
   input  logic [8*LANES-1:0]       rdata_bus,
   output logic [LANES-1:0]         be,
   output logic [8*LANES-1:0]       wdata_bus,
   output logic [LANES-1:0]         take,
   output logic [8*LANES-1:0]       rdata_nat
);

   localparam int OFF_W = $clog2(LANES);

   logic [OFF_W-1:0] lo_mask;
   logic [OFF_W-1:0] hi_mask;
   logic [LANES-1:0] in_req;
   logic [LANES-1:0] sel;
   logic [OFF_W-1:0] lane_of [LANES];

   always_comb begin
      case (wlog)
         2'd0:    lo_mask = OFF_W'(0);
         2'd1:    lo_mask = OFF_W'(1);
         default: lo_mask = OFF_W'(LANES - 1);
      endcase
      hi_mask = ~lo_mask;
   end

   // One slice per natural byte position (0 = most significant).
   generate
      for (genvar b = 0; b < LANES; b++) begin : g_byte
         localparam logic [OFF_W-1:0] BP = OFF_W'(b);
         assign in_req[b]  = (size == SZ_WORD) ||
                             ((size == SZ_HALF) && (BP[OFF_W-1] == req_off[OFF_W-1])) ||
                             ((size == SZ_BYTE) && (BP == req_off));
         assign sel[b]     = in_req[b] && ((BP & hi_mask) == (beat_off & hi_mask));
         assign lane_of[b] = BP & lo_mask;
         assign take[b]    = sel[b];
         assign rdata_nat[8*(LANES-1-b) +: 8] =
            rdata_bus[8*(LANES-1-int'(lane_of[b])) +: 8];
      end
   endgenerate

   always_comb begin
      be        = '0;
      wdata_bus = '0;
      for (int l = 0; l < LANES; l++) begin
         for (int b = 0; b < LANES; b++) begin
            if (sel[b] && (lane_of[b] == OFF_W'(l))) begin
               be[LANES-1-l] = 1'b1;
               if (write) begin
                  wdata_bus[8*(LANES-1-l) +: 8] = wdata_nat[8*(LANES-1-b) +: 8];
               end
            end
         end
      end
   end

endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
   import dbs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  xfer_size_e         req_size,
   input  logic               req_write,
   input  logic [8*LANES-1:0] req_wdata,
   input  plan_t              plan_in,
   output logic [ADDR_W-1:0]  r_addr,
   output xfer_size_e         r_size,
   output logic               r_write,
   output logic [8*LANES-1:0] r_wdata,
   output logic [1:0]         r_wlog,
   output logic [1:0]         idx,
   output logic               beat_last,
   output logic               bt_valid,
   input  logic               bt_ready,
   input  logic [LANES-1:0]   take,
   input  logic [8*LANES-1:0] rdata_nat,
   output logic               rsp_valid,
   output logic               rsp_err,
   output logic [8*LANES-1:0] rsp_rdata
);

   seq_state_e state;
   logic [1:0] r_last;
   logic       r_err;
   logic       accept;
   logic       beat_done;

   assign accept    = req_valid && (state == ST_IDLE);
   assign beat_done = (state == ST_BEAT) && bt_ready;
   assign beat_last = (idx == r_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         r_addr    <= '0;
         r_size    <= SZ_BYTE;
         r_write   <= 1'b0;
         r_wdata   <= '0;
         r_wlog    <= 2'd0;
         r_last    <= 2'd0;
         r_err     <= 1'b0;
         idx       <= 2'd0;
         rsp_rdata <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  r_addr    <= req_addr;
                  r_size    <= req_size;
                  r_write   <= req_write;
                  r_wdata   <= req_wdata;
                  r_wlog    <= plan_in.wlog;
                  r_last    <= plan_in.last_idx;
                  r_err     <= plan_in.err;
                  idx       <= 2'd0;
                  rsp_rdata <= '0;
                  state     <= plan_in.err ? ST_RESP : ST_BEAT;
               end
            end
            ST_BEAT: begin
               if (bt_ready) begin
                  if (!r_write) begin
                     for (int b = 0; b < LANES; b++) begin
                        if (take[b]) begin
                           rsp_rdata[8*(LANES-1-b) +: 8] <= rdata_nat[8*(LANES-1-b) +: 8];
                        end
                     end
                  end
                  if (beat_last) state <= ST_RESP;
                  else           idx   <= idx + 2'd1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign bt_valid  = (state == ST_BEAT);
   assign rsp_valid = (state == ST_RESP);
   assign rsp_err   = r_err;

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid) else $error("rsp pulse too long"); // R1
   AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && plan_in.err) |=> (rsp_valid && rsp_err && !bt_valid))
      else $error("error path issued a beat"); // R7
   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bt_valid && !bt_ready) |=> (bt_valid && $stable(idx)))
      else $error("beat dropped while stalled"); // R8
   AST_DONE_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      (bt_valid && bt_ready && beat_last) |=> (rsp_valid && !rsp_err))
      else $error("no response after last beat"); // R1

endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
   import dbs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit EXT_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_port,
   input  logic              req_ext,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bt_valid,
   input  logic              bt_ready,
   output logic [ADDR_W-1:0] bt_addr,
   output logic              bt_write,
   output logic [DATA_W/8-1:0] bt_be,
   output logic [DATA_W-1:0] bt_wdata,
   input  logic [DATA_W-1:0] bt_rdata
);

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("dyn_bus_sizer: DATA_W must be 32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("dyn_bus_sizer: ADDR_W too small");
      end
   endgenerate

   plan_t             plan;
   logic [ADDR_W-1:0] r_addr;
   xfer_size_e        r_size;
   logic              r_write;
   logic [DATA_W-1:0] r_wdata;
   logic [1:0]        r_wlog;
   logic [1:0]        idx;
   logic              beat_last;
   logic [LANES-1:0]  take;
   logic [DATA_W-1:0] rdata_nat;

   dbs_plan #(.EXT_BYPASS(EXT_BYPASS)) u_plan (
      .addr_lo (req_addr[1:0]),
      .size    (xfer_size_e'(req_size)),
      .port    (port_w_e'(req_port)),
      .ext     (req_ext),
      .plan    (plan)
   );

   dbs_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .req_size  (xfer_size_e'(req_size)),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .plan_in   (plan),
      .r_addr    (r_addr),
      .r_size    (r_size),
      .r_write   (r_write),
      .r_wdata   (r_wdata),
      .r_wlog    (r_wlog),
      .idx       (idx),
      .beat_last (beat_last),
      .bt_valid  (bt_valid),
      .bt_ready  (bt_ready),
      .take      (take),
      .rdata_nat (rdata_nat),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   // Beats step by the port width; single-beat requests stay at idx 0.
   assign bt_addr  = r_addr + (ADDR_W'(idx) << r_wlog);
   assign bt_write = r_write;

   dbs_lane #(.LANES(LANES)) u_lane (
      .beat_off  (bt_addr[OFF_W-1:0]),
      .req_off   (r_addr[OFF_W-1:0]),
      .size      (r_size),
      .wlog      (r_wlog),
      .write     (r_write),
      .wdata_nat (r_wdata),
      .rdata_bus (bt_rdata),
      .be        (bt_be),
      .wdata_bus (bt_wdata),
      .take      (take),
      .rdata_nat (rdata_nat)
   );

   logic [DATA_W-1:0] be_bits;
   always_comb begin
      for (int l = 0; l < LANES; l++) be_bits[8*l +: 8] = {8{bt_be[l]}};
   end

   AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (bt_valid && bt_ready && !beat_last) |=> (bt_valid && (bt_addr > $past(bt_addr))))
      else $error("beat address not ascending"); // R2
   AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (bt_valid && (r_wlog == 2'd0)) |-> (bt_be == 4'b1000))
      else $error("8-bit beat off lane 0"); // R2
   AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (bt_valid && (r_wlog == 2'd1)) |-> ((bt_be[1:0] == 2'b00) && (bt_be != 4'b0000)))
      else $error("16-bit beat outside lanes 0-1"); // R3
   AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bt_valid && !bt_ready) |=> ($stable(bt_addr) && $stable(bt_be) &&
                                   $stable(bt_wdata) && $stable(bt_write)))
      else $error("beat changed while stalled"); // R8
   AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bt_valid |-> ((bt_wdata & ~be_bits) == '0))
      else $error("disabled lane carries data"); // R9

endmodule

// File: tb/dyn_bus_sizer_tb.sv
module dyn_bus_sizer_tb;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [1:0]  req_port = '0;
   logic        req_ext = 1'b0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [31:0] rsp_rdata;
   logic        bt_valid;
   logic        bt_ready = 1'b0;
   logic [31:0] bt_addr;
   logic        bt_write;
   logic [3:0]  bt_be;
   logic [31:0] bt_wdata;
   logic [31:0] bt_rdata = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   dyn_bus_sizer u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .req_port(req_port), .req_ext(req_ext),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bt_valid(bt_valid), .bt_ready(bt_ready), .bt_addr(bt_addr),
      .bt_write(bt_write), .bt_be(bt_be), .bt_wdata(bt_wdata), .bt_rdata(bt_rdata)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_w(logic [1:0] port, logic ext);
      if (ext) return 4;
      case (port)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

   function automatic bit exp_err(logic [31:0] a, logic [1:0] sz, logic [1:0] port, logic ext);
      return (sz == 2'd3) || ((sz == 2'd1) && a[0]) ||
             ((sz == 2'd2) && (a[1:0] != 2'd0)) || (!ext && (port == 2'd3));
   endfunction

   function automatic string port_tag(logic [1:0] port, logic ext);
      if (ext) return "R6";
      case (port)
         2'd0:    return "R2";
         2'd1:    return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic do_req(logic [31:0] a, logic [1:0] sz, logic [1:0] port,
                         logic ext, logic wr, logic [31:0] wd);
      int          w;
      int          nbytes;
      int          nbeats;
      bit          err;
      string       tag;
      logic [31:0] exp_rd;
      err    = exp_err(a, sz, port, ext);
      w      = exp_w(port, ext);
      nbytes = 1 << sz;
      nbeats = (nbytes > w) ? nbytes / w : 1;
      tag    = port_tag(port, ext);
      exp_rd = '0;

      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_port = port;
      req_ext = ext; req_write = wr; req_wdata = wd;
      chk("R1", "req_ready when idle", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;

      if (err) begin
         chk("R7", "rsp_valid on error", {31'd0, rsp_valid}, 32'd1);
         chk("R7", "rsp_err", {31'd0, rsp_err}, 32'd1);
         chk("R7", "no beat on error", {31'd0, bt_valid}, 32'd0);
         return;
      end

      chk("R1", "req_ready busy", {31'd0, req_ready}, 32'd0);
      for (int i = 0; i < nbeats; i++) begin
         logic [31:0] ba;
         int          base;
         logic [3:0]  ebe;
         logic [31:0] ewd;
         logic [31:0] lmask;
         ba   = a + 32'(i * w);
         base = int'(ba[1:0]) & ~(w - 1);
         ebe  = '0;
         ewd  = '0;
         for (int b = 0; b < 4; b++) begin
            if ((b >= int'(a[1:0])) && (b < int'(a[1:0]) + nbytes) &&
                (b >= base) && (b < base + w)) begin
               ebe[3 - (b - base)] = 1'b1;
               if (wr) ewd[8*(3-(b-base)) +: 8] = wd[8*(3-b) +: 8];
            end
         end
         for (int l = 0; l < 4; l++) lmask[8*l +: 8] = {8{ebe[l]}};
         forever begin
            bit rdy;
            chk(tag, "bt_valid", {31'd0, bt_valid}, 32'd1);
            chk(tag, "bt_addr", bt_addr, ba);
            chk(tag, "bt_be", {28'd0, bt_be}, {28'd0, ebe});
            chk(tag, "bt_wdata", bt_wdata & lmask, ewd);
            chk("R9", "unused lanes zero", bt_wdata & ~lmask, 32'd0);
            chk("R9", "bt_write", {31'd0, bt_write}, {31'd0, wr});
            rdy      = ($urandom % 4) != 0;
            bt_ready = rdy;
            bt_rdata = $urandom;
            if (rdy) begin
               for (int b = 0; b < 4; b++) begin
                  if (ebe[3 - (b - base)] && (b >= base) && (b < base + w))
                     exp_rd[8*(3-b) +: 8] = bt_rdata[8*(3-(b-base)) +: 8];
               end
            end
            @(negedge clk);
            if (rdy) break;
         end
      end
      bt_ready = 1'b0;
      chk("R1", "rsp_valid after last beat", {31'd0, rsp_valid}, 32'd1);
      chk("R1", "rsp_err clear", {31'd0, rsp_err}, 32'd0);
      chk("R1", "no beat with response", {31'd0, bt_valid}, 32'd0);
      chk("R5", "rsp_rdata", rsp_rdata, wr ? 32'd0 : exp_rd);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #1;
      chk("R10", "req_ready in reset", {31'd0, req_ready}, 32'd1);
      chk("R10", "bt_valid in reset", {31'd0, bt_valid}, 32'd0);
      chk("R10", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "bt_valid after reset", {31'd0, bt_valid}, 32'd0);
      chk("R10", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

      // Directed corner cases
      do_req(32'h0000_0100, 2'd2, 2'd0, 1'b0, 1'b1, 32'hA1B2_C3D4); // R2 word, 4 beats
      do_req(32'h0000_0202, 2'd1, 2'd0, 1'b0, 1'b0, 32'h0);         // R2 half read
      do_req(32'h0000_0303, 2'd0, 2'd1, 1'b0, 1'b0, 32'h0);         // R3 odd byte
      do_req(32'h0000_0302, 2'd0, 2'd1, 1'b0, 1'b1, 32'h1122_3344); // R3 even byte
      do_req(32'h0000_0404, 2'd2, 2'd1, 1'b0, 1'b0, 32'h0);         // R3 word, 2 beats
      do_req(32'h0000_0502, 2'd1, 2'd2, 1'b0, 1'b1, 32'h5566_7788); // R4 half
      do_req(32'h0000_0600, 2'd2, 2'd0, 1'b1, 1'b0, 32'h0);         // R6 bypass
      do_req(32'h0000_0701, 2'd1, 2'd2, 1'b0, 1'b0, 32'h0);         // R7 odd half
      do_req(32'h0000_0702, 2'd2, 2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF); // R7 unaligned word
      do_req(32'h0000_0800, 2'd3, 2'd2, 1'b0, 1'b0, 32'h0);         // R7 size code 3
      do_req(32'h0000_0900, 2'd0, 2'd3, 1'b0, 1'b0, 32'h0);         // R7 port code 3

      // Constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] a;
         logic [1:0]  sz;
         logic [1:0]  pt;
         a  = $urandom;
         sz = 2'($urandom % 3);
         if (($urandom % 4) != 0) begin
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz == 2'd2) a[1:0] = 2'd0;
         end
         if (($urandom % 40) == 0) sz = 2'd3;
         pt = 2'($urandom % 3);
         if (($urandom % 40) == 0) pt = 2'd3;
         do_req(a, sz, pt, (($urandom % 8) == 0), 1'($urandom), $urandom);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule